// File: doc/BRIEF.md
# Keyed-Hash Authentication Sequencer

This block wraps an external SHA-256 compression engine and drives it through a complete keyed-hash authentication (the inner and outer passes of the HMAC construction) or through a plain single-pass hash. Software loads a 256-bit secret as eight 32-bit words, picks the mode, issues a start command, streams 32-bit message words into a 16-entry buffer and finally issues a process command. The sequencer counts the message length on its own, forms each 512-bit block (key blocks, message blocks, padding and length), hands it to the engine together with the running chaining value, and collects the engine's updated chaining value.

When the final chaining value is known it is copied into eight 32-bit digest words and a sticky done interrupt is raised, which software clears. A separate wipe port overwrites every internal secret (key, chaining value, saved inner digest, digest and the block being assembled) with a 32-bit value supplied by software; the message buffer itself keeps its content.

Top module: `hmac_seq`

## Requirements
- R1: A write with `key_we` stores `key_wdata` in key word `key_idx`; key word i is XORed into block word i of the keyed pad blocks, words 8 to 15 of those blocks hold the pad constant alone.
- R2: The message buffer holds 16 words; `msg_ready` is low while it holds 16, and a word offered while `msg_ready` is low is dropped. Words may be buffered before the start command and are consumed after it.
- R3: In plain mode (`cfg_keyed`=0 at start) the digest is the compression chain, from the standard SHA-256 initial value, over the padded message alone; the key has no effect.
- R4: The length is a 64-bit bit count that grows by 32 per consumed word. Padding puts 0x80000000 in the word after the last data word, zeros after it, and the length (high word, then low word) in block words 14 and 15; when the marker lands in word 14 or 15 an extra block of zeros plus length follows.
- R5: In keyed mode the inner pass hashes the key XOR 0x36 bytes block then the message (length counts the 512 key bits too); the outer pass restarts from the initial value and hashes the key XOR 0x5C bytes block then the eight inner digest words, padded, with length 768.
- R6: Block word j travels on `eng_req_block` bits [511-32j -: 32] and chaining word i on bits [255-32i -: 32]; while `eng_req_valid` is high and `eng_req_ready` low, the request and its data stay unchanged.
- R7: `irq_done` rises in the same cycle the new digest appears, stays high until `irq_clear`, and a set wins over a clear in the same cycle.
- R8: A start command while busy is ignored (mode and progress unchanged); a process command while idle is ignored.
- R9: A wipe write replaces the key, the chaining value, the saved inner digest, the digest and the assembled block with the written value repeated, one cycle later; the message buffer is untouched.
- R10: A wipe and a key-word write in the same cycle leave every key word equal to the wipe value.
- R11: Digest word i sits on `digest_o` bits [255-32i -: 32]; it is zero after reset and changes only on completion or wipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_keyed | input | 1 | Mode sampled at start: 1 keyed, 0 plain hash |
| cmd_start | input | 1 | Start pulse |
| cmd_process | input | 1 | End-of-message pulse |
| irq_clear | input | 1 | Clears the done interrupt |
| key_we | input | 1 | Key word write strobe |
| key_idx | input | 3 | Key word index |
| key_wdata | input | 32 | Key word value |
| msg_valid | input | 1 | Message word offered |
| msg_data | input | 32 | Message word |
| msg_ready | output | 1 | Buffer has room |
| wipe_we | input | 1 | Wipe strobe |
| wipe_data | input | 32 | Value written over all secrets |
| eng_req_valid | output | 1 | Block ready for the engine |
| eng_req_ready | input | 1 | Engine accepts the block |
| eng_req_block | output | 512 | Block, word 0 in the top bits |
| eng_req_state | output | 256 | Chaining value in |
| eng_rsp_valid | input | 1 | Engine result valid |
| eng_rsp_state | input | 256 | Chaining value out |
| digest_o | output | 256 | Digest, word 0 in the top bits |
| irq_done | output | 1 | Sticky done interrupt |
| busy | output | 1 | A hash is in progress |

## Verification
A wipe and a key-word write can land in the same cycle; the bench drives both on one edge and then runs a keyed hash, whose digest must match a model where all eight key words hold the wipe value. A start command can also collide with an active message stream: the bench injects a second start with the opposite mode halfway through pushing words and judges the run by its digest, which must match the original mode and the full message. A stalled engine handshake is provoked by varying the engine's latency and ready gap per run.

// File: rtl/hmac_seq_pkg.sv
package hmac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INNER_KEY,
    ST_MSG,
    ST_PAD,
    ST_OUTER_KEY,
    ST_OUTER_MSG,
    ST_DONE
  } seq_state_e;

  localparam logic [31:0] PAD_MARK = 32'h8000_0000;
  localparam logic [7:0]  IPAD_BYTE = 8'h36;
  localparam logic [7:0]  OPAD_BYTE = 8'h5C;

  // Standard SHA-256 initial chaining value, word 0 in the top bits.
  function automatic logic [255:0] sha_iv();
    return {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
            32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  endfunction

endpackage

// File: rtl/hmac_seq_fifo.sv
module hmac_seq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] cnt
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/hmac_seq_keystore.sv
module hmac_seq_keystore #(
  parameter int DW    = 32,
  parameter int WORDS = 8,
  localparam int IW   = $clog2(WORDS),
  localparam int KW   = DW * WORDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic          wipe_we,
  input  logic [DW-1:0] wipe_data,
  output logic [KW-1:0] key_flat
);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                           word_q <= '0;
      else if (wipe_we)                  word_q <= wipe_data;
      else if (we && idx == IW'(i))      word_q <= wdata;
    end
    assign key_flat[KW-1-DW*i -: DW] = word_q;
  end

endmodule

// File: rtl/hmac_seq_lenctr.sv
module hmac_seq_lenctr #(
  parameter int LW   = 64,
  parameter int STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          inc,
  output logic [LW-1:0] len
);

  always_ff @(posedge clk) begin
    if (rst)       len <= '0;
    else if (load) len <= load_val;
    else if (inc)  len <= len + LW'(STEP);
  end

endmodule

// File: rtl/hmac_seq.sv
module hmac_seq
  import hmac_seq_pkg::*;
#(
  parameter int DW         = 32,
  parameter int KEY_WORDS  = 8,
  parameter int BLK_WORDS  = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 64,
  localparam int KIW       = $clog2(KEY_WORDS),
  localparam int HW        = DW * KEY_WORDS,
  localparam int BW        = DW * BLK_WORDS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_keyed,
  input  logic           cmd_start,
  input  logic           cmd_process,
  input  logic           irq_clear,
  input  logic           key_we,
  input  logic [KIW-1:0] key_idx,
  input  logic [DW-1:0]  key_wdata,
  input  logic           msg_valid,
  input  logic [DW-1:0]  msg_data,
  output logic           msg_ready,
  input  logic           wipe_we,
  input  logic [DW-1:0]  wipe_data,
  output logic           eng_req_valid,
  input  logic           eng_req_ready,
  output logic [BW-1:0]  eng_req_block,
  output logic [HW-1:0]  eng_req_state,
  input  logic           eng_rsp_valid,
  input  logic [HW-1:0]  eng_rsp_state,
  output logic [HW-1:0]  digest_o,
  output logic           irq_done,
  output logic           busy
);

  localparam int WPW       = $clog2(BLK_WORDS);
  localparam int FCW       = $clog2(FIFO_DEPTH + 1);
  localparam int LEN_WORDS = LEN_W / DW;
  localparam int LAST_DATA = BLK_WORDS - LEN_WORDS;
  localparam int OUTER_LEN = (BLK_WORDS + KEY_WORDS) * DW;
  localparam logic [DW-1:0] IPAD_W = {(DW/8){IPAD_BYTE}};
  localparam logic [DW-1:0] OPAD_W = {(DW/8){OPAD_BYTE}};

  seq_state_e state;
  logic                            mode_q, proc_seen, mark_done, fin_done;
  logic                            blk_pend, wait_rsp, eng_idle;
  logic [WPW-1:0]                  wptr;
  logic [BLK_WORDS-1:0][DW-1:0]    blk_q;
  logic [HW-1:0]                   h_q, ih_q, digest_q;
  logic [HW-1:0]                   key_flat;
  logic [LEN_W-1:0]                len_q;
  logic [DW-1:0]                   fifo_rdata;
  logic                            fifo_full, fifo_empty, fifo_pop, dig_upd;
  logic [FCW-1:0]                  fifo_cnt;
  logic                            len_load;
  logic [LEN_W-1:0]                len_init;

  hmac_seq_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (msg_valid),
    .wdata (msg_data),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .full  (fifo_full),
    .empty (fifo_empty),
    .cnt   (fifo_cnt)
  );

  hmac_seq_keystore #(.DW(DW), .WORDS(KEY_WORDS)) u_keys (
    .clk       (clk),
    .rst       (rst),
    .we        (key_we),
    .idx       (key_idx),
    .wdata     (key_wdata),
    .wipe_we   (wipe_we),
    .wipe_data (wipe_data),
    .key_flat  (key_flat)
  );

  assign len_load = (state == ST_IDLE) && cmd_start;
  assign len_init = cfg_keyed ? LEN_W'(BW) : '0;

  hmac_seq_lenctr #(.LW(LEN_W), .STEP(DW)) u_len (
    .clk      (clk),
    .rst      (rst),
    .load     (len_load),
    .load_val (len_init),
    .inc      (fifo_pop),
    .len      (len_q)
  );

  assign eng_idle  = !blk_pend && !wait_rsp;
  assign fifo_pop  = (state == ST_MSG) && eng_idle && !fifo_empty;
  assign dig_upd   = (state == ST_DONE);
  assign msg_ready = !fifo_full;
  assign busy      = (state != ST_IDLE);

  assign eng_req_valid = blk_pend;
  assign eng_req_state = h_q;
  assign digest_o      = digest_q;

  for (genvar j = 0; j < BLK_WORDS; j++) begin : g_blk
    assign eng_req_block[BW-1-DW*j -: DW] = blk_q[j];
  end

  function automatic logic [DW-1:0] key_word(input logic [HW-1:0] k, input int j);
    return (j < KEY_WORDS) ? k[HW-1-DW*j -: DW] : '0;
  endfunction

  function automatic logic [DW-1:0] len_word(input logic [LEN_W-1:0] l, input int j);
    return l[LEN_W-1-DW*(j-LAST_DATA) -: DW];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= 1'b0;
      proc_seen <= 1'b0;
      mark_done <= 1'b0;
      fin_done  <= 1'b0;
      blk_pend  <= 1'b0;
      wait_rsp  <= 1'b0;
      wptr      <= '0;
      blk_q     <= '0;
      h_q       <= '0;
      ih_q      <= '0;
      digest_q  <= '0;
    end else begin
      if (cmd_process && state != ST_IDLE) proc_seen <= 1'b1;
      if (eng_req_valid && eng_req_ready) begin
        blk_pend <= 1'b0;
        wait_rsp <= 1'b1;
      end
      if (wait_rsp && eng_rsp_valid) begin
        wait_rsp <= 1'b0;
        h_q      <= eng_rsp_state;
      end

      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            mode_q    <= cfg_keyed;
            h_q       <= sha_iv();
            wptr      <= '0;
            mark_done <= 1'b0;
            fin_done  <= 1'b0;
            proc_seen <= 1'b0;
            if (cfg_keyed) begin
              for (int j = 0; j < BLK_WORDS; j++) blk_q[j] <= key_word(key_flat, j) ^ IPAD_W;
              blk_pend <= 1'b1;
              state    <= ST_INNER_KEY;
            end else begin
              state <= ST_MSG;
            end
          end
        end
        ST_INNER_KEY: begin
          if (eng_idle) state <= ST_MSG;
        end
        ST_MSG: begin
          if (eng_idle) begin
            if (!fifo_empty) begin
              blk_q[wptr] <= fifo_rdata;
              if (wptr == WPW'(BLK_WORDS - 1)) begin
                wptr     <= '0;
                blk_pend <= 1'b1;
              end else begin
                wptr <= wptr + 1'b1;
              end
            end else if (proc_seen) begin
              state <= ST_PAD;
            end
          end
        end
        ST_PAD: begin
          if (eng_idle) begin
            if (!mark_done) begin
              for (int j = 0; j < BLK_WORDS; j++) begin
                if (j == int'(wptr))       blk_q[j] <= PAD_MARK;
                else if (j > int'(wptr))   blk_q[j] <= '0;
                if (int'(wptr) < LAST_DATA && j >= LAST_DATA) blk_q[j] <= len_word(len_q, j);
              end
              mark_done <= 1'b1;
              fin_done  <= (int'(wptr) < LAST_DATA);
              blk_pend  <= 1'b1;
            end else if (!fin_done) begin
              for (int j = 0; j < BLK_WORDS; j++)
                blk_q[j] <= (j >= LAST_DATA) ? len_word(len_q, j) : '0;
              fin_done <= 1'b1;
              blk_pend <= 1'b1;
            end else if (mode_q) begin
              ih_q     <= h_q;
              h_q      <= sha_iv();
              for (int j = 0; j < BLK_WORDS; j++) blk_q[j] <= key_word(key_flat, j) ^ OPAD_W;
              blk_pend <= 1'b1;
              state    <= ST_OUTER_KEY;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_OUTER_KEY: begin
          if (eng_idle) begin
            for (int j = 0; j < BLK_WORDS; j++) begin
              if (j < KEY_WORDS)        blk_q[j] <= ih_q[HW-1-DW*j -: DW];
              else if (j == KEY_WORDS)  blk_q[j] <= PAD_MARK;
              else if (j >= LAST_DATA)  blk_q[j] <= len_word(LEN_W'(OUTER_LEN), j);
              else                      blk_q[j] <= '0;
            end
            blk_pend <= 1'b1;
            state    <= ST_OUTER_MSG;
          end
        end
        ST_OUTER_MSG: begin
          if (eng_idle) state <= ST_DONE;
        end
        ST_DONE: begin
          digest_q <= h_q;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase

      if (wipe_we) begin
        blk_q    <= {BLK_WORDS{wipe_data}};
        h_q      <= {KEY_WORDS{wipe_data}};
        ih_q     <= {KEY_WORDS{wipe_data}};
        digest_q <= {KEY_WORDS{wipe_data}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            irq_done <= 1'b0;
    else if (dig_upd)   irq_done <= 1'b1;
    else if (irq_clear) irq_done <= 1'b0;
  end

endmodule

// File: rtl/hmac_seq_chk.sv
module hmac_seq_chk #(
  parameter int DW         = 32,
  parameter int KEY_WORDS  = 8,
  parameter int BLK_WORDS  = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 64,
  localparam int HW        = DW * KEY_WORDS,
  localparam int BW        = DW * BLK_WORDS,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             eng_req_valid,
  input logic             eng_req_ready,
  input logic [BW-1:0]    eng_req_block,
  input logic [HW-1:0]    eng_req_state,
  input logic             irq_done,
  input logic             irq_clear,
  input logic [HW-1:0]    digest_o,
  input logic             wipe_we,
  input logic [DW-1:0]    wipe_data,
  input logic [HW-1:0]    key_flat,
  input logic             busy,
  input logic             mode_q,
  input logic [FCW-1:0]   fifo_cnt,
  input logic             fifo_pop,
  input logic [LEN_W-1:0] len_q,
  input logic             dig_upd
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    eng_req_valid && !eng_req_ready && !wipe_we |=>
      eng_req_valid && $stable(eng_req_block) && $stable(eng_req_state)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_done && !irq_clear |=> irq_done); // R7

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    dig_upd |=> irq_done); // R7

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode_q)); // R8

  AST_WIPE_SECRETS: assert property (@(posedge clk) disable iff (rst)
    wipe_we |=> digest_o == {KEY_WORDS{$past(wipe_data)}}
             && eng_req_state == {KEY_WORDS{$past(wipe_data)}}
             && eng_req_block == {BLK_WORDS{$past(wipe_data)}}); // R9

  AST_WIPE_KEY: assert property (@(posedge clk) disable iff (rst)
    wipe_we |=> key_flat == {KEY_WORDS{$past(wipe_data)}}); // R10

  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wipe_we && !dig_upd |=> $stable(digest_o)); // R11

  AST_LEN_STEP: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> len_q == $past(len_q) + LEN_W'(DW)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= FCW'(FIFO_DEPTH)); // R2

endmodule

bind hmac_seq hmac_seq_chk #(
  .DW(DW), .KEY_WORDS(KEY_WORDS), .BLK_WORDS(BLK_WORDS),
  .FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .eng_req_valid (eng_req_valid),
  .eng_req_ready (eng_req_ready),
  .eng_req_block (eng_req_block),
  .eng_req_state (eng_req_state),
  .irq_done      (irq_done),
  .irq_clear     (irq_clear),
  .digest_o      (digest_o),
  .wipe_we       (wipe_we),
  .wipe_data     (wipe_data),
  .key_flat      (key_flat),
  .busy          (busy),
  .mode_q        (mode_q),
  .fifo_cnt      (fifo_cnt),
  .fifo_pop      (fifo_pop),
  .len_q         (len_q),
  .dig_upd       (dig_upd)
);

// File: tb/hmac_seq_bench.sv
module hmac_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_keyed = 1'b0, cmd_start = 1'b0, cmd_process = 1'b0, irq_clear = 1'b0;
  logic         key_we = 1'b0;
  logic [2:0]   key_idx = '0;
  logic [31:0]  key_wdata = '0;
  logic         msg_valid = 1'b0;
  logic [31:0]  msg_data = '0;
  logic         msg_ready;
  logic         wipe_we = 1'b0;
  logic [31:0]  wipe_data = '0;
  logic         eng_req_valid, eng_req_ready;
  logic [511:0] eng_req_block;
  logic [255:0] eng_req_state;
  logic         eng_rsp_valid;
  logic [255:0] eng_rsp_state;
  logic [255:0] digest_o;
  logic         irq_done, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  hmac_seq u_hmac_seq (
    .clk(clk), .rst(rst), .cfg_keyed(cfg_keyed), .cmd_start(cmd_start),
    .cmd_process(cmd_process), .irq_clear(irq_clear), .key_we(key_we),
    .key_idx(key_idx), .key_wdata(key_wdata), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_ready(msg_ready), .wipe_we(wipe_we),
    .wipe_data(wipe_data), .eng_req_valid(eng_req_valid),
    .eng_req_ready(eng_req_ready), .eng_req_block(eng_req_block),
    .eng_req_state(eng_req_state), .eng_rsp_valid(eng_rsp_valid),
    .eng_rsp_state(eng_rsp_state), .digest_o(digest_o),
    .irq_done(irq_done), .busy(busy)
  );

  // Toy compression used by both the engine model and the reference model.
  function automatic logic [255:0] comp(input logic [255:0] h, input logic [511:0] b);
    logic [31:0]  acc, w;
    logic [255:0] r;
    acc = 32'h6b43_a9b5;
    for (int j = 0; j < 16; j++) acc = ({acc[26:0], acc[31:27]} ^ b[511-32*j -: 32]) + 32'h9e37_79b9;
    for (int i = 0; i < 8; i++) begin
      w = h[255-32*i -: 32];
      r[255-32*i -: 32] = ({w[30:0], w[31]} ^ acc) + b[32*i +: 32];
      acc = acc * 32'd5 + 32'd1;
    end
    return r;
  endfunction

  // Engine model with per-run latency and ready gap.
  int           cfg_lat = 0, cfg_gap = 0;
  logic         e_busy;
  int           e_cnt, e_gap;
  logic [255:0] e_res;

  always @(posedge clk) begin
    if (rst) begin
      eng_req_ready <= 1'b0; eng_rsp_valid <= 1'b0; eng_rsp_state <= '0;
      e_busy <= 1'b0; e_cnt <= 0; e_gap <= 0; e_res <= '0;
    end else begin
      eng_rsp_valid <= 1'b0;
      if (e_busy) begin
        if (e_cnt == 0) begin
          eng_rsp_valid <= 1'b1; eng_rsp_state <= e_res; e_busy <= 1'b0; e_gap <= cfg_gap;
        end else e_cnt <= e_cnt - 1;
      end else if (eng_req_ready && eng_req_valid) begin
        e_res <= comp(eng_req_state, eng_req_block);
        e_busy <= 1'b1; e_cnt <= cfg_lat; eng_req_ready <= 1'b0;
      end else if (e_gap != 0) e_gap <= e_gap - 1;
      else eng_req_ready <= 1'b1;
    end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model.
  logic [31:0] kw [8];
  logic [31:0] mw [64];
  logic [31:0] pw [128];
  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  task automatic run_chain(input int nw, output logic [255:0] d);
    int k;
    logic [511:0] b;
    pw[nw] = 32'h8000_0000;
    k = nw + 1;
    while (k % 16 != 14) begin pw[k] = '0; k++; end
    pw[k] = '0; pw[k+1] = 32'(nw * 32);
    k = k + 2;
    d = IV;
    for (int bi = 0; bi < k / 16; bi++) begin
      for (int j = 0; j < 16; j++) b[511-32*j -: 32] = pw[16*bi + j];
      d = comp(d, b);
    end
  endtask

  task automatic expect_hash(input bit keyed, input int n, output logic [255:0] d);
    logic [255:0] inner;
    if (!keyed) begin
      for (int i = 0; i < n; i++) pw[i] = mw[i];
      run_chain(n, d);
    end else begin
      for (int j = 0; j < 16; j++) pw[j] = ((j < 8) ? kw[j] : 32'h0) ^ 32'h3636_3636;
      for (int i = 0; i < n; i++) pw[16+i] = mw[i];
      run_chain(16 + n, inner);
      for (int j = 0; j < 16; j++) pw[j] = ((j < 8) ? kw[j] : 32'h0) ^ 32'h5c5c_5c5c;
      for (int i = 0; i < 8; i++) pw[16+i] = inner[255-32*i -: 32];
      run_chain(24, d);
    end
  endtask

  task automatic fill_msg(input int seed);
    for (int i = 0; i < 64; i++) mw[i] = (32'(seed) * 32'h0101_0007) ^ (32'(i) * 32'h2f3b_1d05) ^ 32'ha500_0000;
  endtask

  task automatic write_key(input int idx, input logic [31:0] v);
    @(negedge clk); key_we = 1; key_idx = 3'(idx); key_wdata = v;
    @(negedge clk); key_we = 0;
    kw[idx] = v;
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      while (!msg_ready) @(negedge clk);
      msg_valid = 1; msg_data = mw[i];
      @(negedge clk); msg_valid = 0;
    end
  endtask

  task automatic run_hash(input bit keyed, input int n, input bit do_push, input bit extra_start, input string tag);
    logic [255:0] exp, pre;
    int guard;
    pre = digest_o;
    cfg_lat = n % 4; cfg_gap = (n + 1) % 3;
    @(negedge clk); cfg_keyed = keyed; cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    if (do_push) begin
      for (int i = 0; i < n; i++) begin
        while (!msg_ready) @(negedge clk);
        msg_valid = 1; msg_data = mw[i];
        @(negedge clk); msg_valid = 0;
        if (extra_start && i == n / 2) begin
          cfg_keyed = !keyed; cmd_start = 1;
          @(negedge clk); cmd_start = 0; cfg_keyed = keyed;
        end
      end
    end
    chk(digest_o == pre, "R11 digest held while busy", digest_o, pre);
    cmd_process = 1;
    @(negedge clk); cmd_process = 0;
    guard = 0;
    while (!irq_done && guard < 4000) begin @(negedge clk); guard++; end
    expect_hash(keyed, n, exp);
    chk(digest_o == exp, tag, digest_o, exp);
    repeat (3) @(negedge clk);
    chk(irq_done == 1'b1, "R7 irq sticky", 256'(irq_done), 256'(1));
    irq_clear = 1;
    @(negedge clk); irq_clear = 0;
    chk(irq_done == 1'b0 && busy == 1'b0, "R7 irq cleared", 256'({irq_done, busy}), 256'(0));
  endtask

  initial begin
    logic [255:0] d1;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(digest_o == '0, "R11 reset digest", digest_o, '0);
    chk(irq_done == 0 && busy == 0, "R7 reset irq/busy", 256'({irq_done, busy}), 256'(0));
    chk(msg_ready == 1, "R2 reset ready", 256'(msg_ready), 256'(1));
    for (int i = 0; i < 8; i++) kw[i] = '0;

    // R2: fill the buffer while idle, 17th word dropped.
    fill_msg(99);
    push_words(16);
    chk(msg_ready == 0, "R2 full at 16", 256'(msg_ready), 256'(0));
    msg_valid = 1; msg_data = 32'hdead_beef;
    @(negedge clk); msg_valid = 0;
    run_hash(0, 16, 0, 0, "R2 prefilled 16 words, extra dropped");

    // R1: load all key words.
    for (int i = 0; i < 8; i++) write_key(i, 32'h1000_0001 * 32'(i + 3) ^ 32'h0bad_f00d);

    // R3/R4: plain sweep across every pad position.
    for (int n = 0; n <= 33; n++) begin
      fill_msg(n);
      run_hash(0, n, 1, 0, $sformatf("R4 plain n=%0d", n));
    end

    // R5/R1: keyed sweep, with a start injected mid-stream (R8).
    for (int n = 0; n <= 20; n++) begin
      fill_msg(100 + n);
      run_hash(1, n, 1, (n == 7), $sformatf("R5 keyed n=%0d", n));
    end

    // R3: key has no effect in plain mode.
    fill_msg(7);
    run_hash(0, 5, 1, 0, "R3 plain before key change");
    d1 = digest_o;
    write_key(2, 32'h7777_1234);
    run_hash(0, 5, 1, 0, "R3 plain after key change");
    chk(digest_o == d1, "R3 key ignored", digest_o, d1);

    // R8: process while idle ignored; start while busy ignored.
    @(negedge clk); cmd_process = 1;
    @(negedge clk); cmd_process = 0;
    fill_msg(55);
    run_hash(1, 6, 1, 1, "R8 idle process and busy start ignored");
    fill_msg(56);
    run_hash(0, 9, 1, 1, "R8 busy start ignored plain");

    // R9: wipe.
    fill_msg(77);
    push_words(3);
    @(negedge clk); wipe_we = 1; wipe_data = 32'hc0ff_ee11;
    @(negedge clk); wipe_we = 0;
    chk(digest_o == {8{32'hc0ff_ee11}}, "R9 digest wiped", digest_o, {8{32'hc0ff_ee11}});
    for (int i = 0; i < 8; i++) kw[i] = 32'hc0ff_ee11;
    run_hash(0, 3, 0, 0, "R9 buffer kept across wipe");
    fill_msg(78);
    run_hash(1, 2, 1, 0, "R9 key wiped");

    // R10: wipe and key write together.
    @(negedge clk); wipe_we = 1; wipe_data = 32'h5a5a_0f0f; key_we = 1; key_idx = 3'd5; key_wdata = 32'h1111_2222;
    @(negedge clk); wipe_we = 0; key_we = 0;
    for (int i = 0; i < 8; i++) kw[i] = 32'h5a5a_0f0f;
    fill_msg(79);
    run_hash(1, 4, 1, 0, "R10 wipe beats key write");

    // R1: single word update after wipe.
    write_key(5, 32'h1111_2222);
    run_hash(1, 4, 1, 0, "R1 single key word write");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule